// File: doc/BRIEF.md
# CAN Receive Bit Sampling Timer

This block turns an oversampled CAN receive line into a stream of bit samples. It runs on a clock that is many times faster than the bit rate. While the bus is quiet it watches the line for the first dominant (low) level. It takes the clock edge where that level appears as the origin of the frame. From then on it samples the line on a fixed grid measured from that origin. Bit n is taken at origin + n × period + offset. Every target is built up exactly from the origin, so a bit period that is not a whole number of clocks never drifts. The block does not move the grid on later edges of the line.

Each sample comes out as a one-cycle `bit_valid` strobe. The strobe carries the sampled level and the running bit number. The number counts every sampled bit, including the ones that a downstream decoder will later discard as stuff bits. The bit period is an unsigned fixed-point value with 16 fractional bits. At 1 Mbit/s it equals the clock rate divided by 1,000,000. The sample offset is a whole number of clocks, usually about 70 % of the period. Both values are taken from the inputs at the origin and held for the rest of the frame. When the downstream decoder raises `frame_done`, the block goes back to waiting for the next dominant level.

The controller has two states. `ST_IDLE` waits for the line. `ST_RUN` produces samples. The START transition goes from `ST_IDLE` to `ST_RUN` when the line is sampled low in idle. The FINISH transition goes from `ST_RUN` back to `ST_IDLE` when `frame_done` is high. A synchronous reset forces `ST_IDLE` from any state.

Top module: `can_bit_sampler`

## Requirements
- R1: When `rst` is high at a clock edge, the block enters `ST_IDLE`, `bit_valid` becomes 0 and `bit_index` becomes 0.
- R2: In `ST_IDLE`, `bit_valid` stays 0, and a high (recessive) line leaves the block in `ST_IDLE`.
- R3: The origin is the first clock edge in `ST_IDLE` at which `rx` is sampled low. Bit 0 of the frame is sampled `floor(sample_offset)` edges after the origin.
- R4: Bit n is sampled at edge origin + floor(n × P + O). P is `bit_period` read as an unsigned number with 16 fractional bits. O is `sample_offset` in whole clocks. No error accumulates over the frame, and no strobe occurs at any other edge of the frame.
- R5: A sample raises `bit_valid` for exactly one cycle after its edge. During that cycle `bit_value` equals the `rx` level at the sampling edge.
- R6: `bit_index` presented with a strobe is 0 for the first sample of a frame and rises by one for each later sample, whatever the bit values are.
- R7: `bit_period` and `sample_offset` are captured at the origin. Changing them during a frame has no effect on that frame's sample times.
- R8: `frame_done` high at an edge in `ST_RUN` returns the block to `ST_IDLE`. It suppresses any sample due at that edge, and the next frame's numbering starts again from 0.
- R9: Use is defined for an integer part of `bit_period` of at least 1 and for `sample_offset` of at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rx | input | 1 | Receive line, 0 = dominant |
| frame_done | input | 1 | Downstream end-of-frame, returns to idle |
| bit_period | input | INT_W+FRAC_W (28) | Bit period in clocks, 16 fractional bits |
| sample_offset | input | INT_W (12) | Sample point offset in whole clocks |
| bit_valid | output | 1 | One-cycle sample strobe |
| bit_value | output | 1 | Line level at the sample |
| bit_index | output | IDX_W (8) | Bit number within the frame |

## Verification
The bench builds the block with its default widths. The 12-bit integer period part and the 8-bit index cover periods from 2 to 30 clocks and frames of up to 100 bits without wrap-around. The 16 fractional bits are exercised with periods such as 10.5 clocks over a long frame, where any drift in the grid would show up as a strobe one edge early or late. The bench checks every edge of every frame: a strobe must appear at each due edge and nowhere else. It also covers the case where `frame_done` lands on a sampling edge, and frames whose configuration inputs move at random after the origin.

// File: rtl/can_bs_pkg.sv
package can_bs_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cbs_state_e;
endpackage

// File: rtl/cbs_elapsed_ctr.sv
// Counts clock edges since the frame origin; the value names the edge being evaluated.
module cbs_elapsed_ctr #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             en,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= CNT_W'(1);
        end else if (en) begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/cbs_target_acc.sv
// Fixed-point running target: starts at the offset, adds one period per sample.
module cbs_target_acc #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 16,
    parameter int CNT_W  = 21
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    step,
    input  logic [INT_W+FRAC_W-1:0] period,
    input  logic [INT_W-1:0]        offset,
    output logic [CNT_W-1:0]        target_int
);
    localparam int PER_W = INT_W + FRAC_W;
    localparam int TGT_W = CNT_W + FRAC_W;

    logic [PER_W-1:0] per_q;
    logic [TGT_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= '0;
            acc_q <= '0;
        end else if (load) begin
            per_q <= period;
            acc_q <= TGT_W'({offset, {FRAC_W{1'b0}}});
        end else if (step) begin
            acc_q <= acc_q + TGT_W'(per_q);
        end
    end

    assign target_int = acc_q[TGT_W-1:FRAC_W];
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 16,
    parameter int IDX_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rx,
    input  logic                    frame_done,
    input  logic [INT_W+FRAC_W-1:0] bit_period,
    input  logic [INT_W-1:0]        sample_offset,
    output logic                    bit_valid,
    output logic                    bit_value,
    output logic [IDX_W-1:0]        bit_index
);
    import can_bs_pkg::*;

    localparam int CNT_W = INT_W + IDX_W + 1;

    cbs_state_e       state, state_nx;
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] due_edge;
    logic [IDX_W-1:0] seq_q;
    logic             start;
    logic             hit;
    logic             take;

    assign start = (state == ST_IDLE) && !rx;
    assign hit   = (state == ST_RUN) && (elapsed == due_edge);
    assign take  = hit && !frame_done;

    cbs_elapsed_ctr #(.CNT_W(CNT_W)) i_elapsed (
        .clk   (clk),
        .rst   (rst),
        .load  (start),
        .en    (state == ST_RUN),
        .count (elapsed)
    );

    cbs_target_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) i_target (
        .clk        (clk),
        .rst        (rst),
        .load       (start),
        .step       (hit),
        .period     (bit_period),
        .offset     (sample_offset),
        .target_int (due_edge)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (!rx)       state_nx = ST_RUN;
            ST_RUN:  if (frame_done) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_valid <= 1'b0;
            bit_value <= 1'b1;
            bit_index <= '0;
            seq_q     <= '0;
        end else begin
            bit_valid <= take;
            if (start) begin
                seq_q <= '0;
            end else if (take) begin
                bit_value <= rx;
                bit_index <= seq_q;
                seq_q     <= seq_q + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
    parameter int IDX_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    frame_done,
    input logic                    bit_valid,
    input logic                    bit_value,
    input logic [IDX_W-1:0]        bit_index,
    input can_bs_pkg::cbs_state_e  st
);
    import can_bs_pkg::*;

    logic             seen_q;
    logic [IDX_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst || st == ST_IDLE) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (bit_valid) begin
            seen_q <= 1'b1;
            last_q <= bit_index;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bit_valid && bit_index == '0));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |=> !bit_valid);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !bit_valid);

    assert_first_index_R6: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !seen_q) |-> (bit_index == '0));

    assert_index_step_R6: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && seen_q) |-> (bit_index == last_q + IDX_W'(1)));

    assert_value_known_R5: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> !$isunknown(bit_value));
endmodule

bind can_bit_sampler cbs_checker #(.IDX_W(IDX_W)) i_cbs_checker (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .bit_valid  (bit_valid),
    .bit_value  (bit_value),
    .bit_index  (bit_index),
    .st         (state)
);

// File: tb/test_can_bit_sampler.sv
module test_can_bit_sampler;
    localparam int INT_W  = 12;
    localparam int FRAC_W = 16;
    localparam int IDX_W  = 8;
    localparam int PER_W  = INT_W + FRAC_W;

    logic             clk = 1'b0;
    logic             rst;
    logic             rx;
    logic             fd;
    logic [PER_W-1:0] per;
    logic [INT_W-1:0] off;
    logic             bit_valid;
    logic             bit_value;
    logic [IDX_W-1:0] bit_index;

    always #5 clk = ~clk;

    can_bit_sampler #(.INT_W(INT_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W)) i_can_bit_sampler (
        .clk           (clk),
        .rst           (rst),
        .rx            (rx),
        .frame_done    (fd),
        .bit_period    (per),
        .sample_offset (off),
        .bit_valid     (bit_valid),
        .bit_value     (bit_value),
        .bit_index     (bit_index)
    );

    longint tick = 0;
    always @(posedge clk) tick <= tick + 1;

    int     checks   = 0;
    int     failures = 0;
    bit     finished = 1'b0;
    bit     m_run    = 1'b0;
    bit     cfg_moved = 1'b0;
    longint t0, mn, mP, mOff;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)", req, what, act, exp, tick);
        end
    endtask

    function automatic longint due();
        return t0 + ((mn * mP + (mOff << FRAC_W)) >>> FRAC_W);
    endfunction

    // Reference model evaluated for the edge just past; inputs are still those applied at it.
    task automatic observe();
        if (rst) begin
            chk(!bit_valid && bit_index == 0, "R1", "valid/index after reset",
                {bit_valid, bit_index}, 0);
            m_run = 1'b0;
        end else if (!m_run) begin
            chk(bit_valid == 1'b0, "R2", "strobe in idle", bit_valid, 0);
            if (rx == 1'b0) begin
                m_run = 1'b1; t0 = tick; mn = 0; mP = per; mOff = off;
            end
        end else if (fd) begin
            chk(bit_valid == 1'b0, "R8", "strobe on frame_done edge", bit_valid, 0);
            m_run = 1'b0;
        end else if (tick == due()) begin
            chk(bit_valid == 1'b1, (mn == 0) ? "R3" : (cfg_moved ? "R7" : "R4"),
                "missing strobe at due edge", bit_valid, 1);
            chk(bit_value == rx, "R5", "sampled value", bit_value, rx);
            chk(bit_index == IDX_W'(mn), "R6", "bit index", bit_index, mn);
            mn++;
        end else begin
            chk(bit_valid == 1'b0, cfg_moved ? "R7" : "R4", "strobe off grid", bit_valid, 0);
        end
    endtask

    task automatic run_frame(input longint P, input longint O, input int nbits,
                             input bit collide, input bit wiggle);
        per = PER_W'(P); off = INT_W'(O); cfg_moved = 1'b0;
        repeat (3) begin @(negedge clk); observe(); rx = 1'b1; fd = 1'b0; end
        @(negedge clk); observe(); rx = 1'b0;
        forever begin
            @(negedge clk); observe();
            if (m_run && mn >= nbits && (!collide || tick + 1 == due())) begin
                fd = 1'b1; rx = 1'($urandom);
                @(negedge clk); observe();
                fd = 1'b0; rx = 1'b1;
                break;
            end
            rx = 1'($urandom);
            if (wiggle && m_run) begin
                per = PER_W'(($urandom % 40 + 1) << FRAC_W);
                off = INT_W'($urandom % 30 + 1);
                cfg_moved = 1'b1;
            end
        end
        per = PER_W'(P); off = INT_W'(O);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; rx = 1'b1; fd = 1'b0; per = PER_W'(10 << FRAC_W); off = 7;
        repeat (3) begin @(negedge clk); observe(); end
        rst = 1'b0;
        // R2: recessive line in idle yields no strobes
        repeat (30) begin @(negedge clk); observe(); rx = 1'b1; end
        // R4 whole period, R3 first bit
        run_frame(10 << FRAC_W, 7, 20, 1'b0, 1'b0);
        // R4 fractional period over a long frame: no drift
        run_frame((10 << FRAC_W) | 32'h8000, 7, 100, 1'b0, 1'b0);
        // R8 frame_done on a sampling edge
        run_frame(12 << FRAC_W, 8, 15, 1'b1, 1'b0);
        // R7 configuration moved mid-frame
        run_frame(9 << FRAC_W, 6, 25, 1'b0, 1'b1);
        // R9 smallest legal period and offset
        run_frame(2 << FRAC_W, 1, 30, 1'b0, 1'b0);
        run_frame((1 << FRAC_W) | 32'h4000, 1, 20, 1'b0, 1'b0);
        for (int f = 0; f < 25; f++) begin
            longint pi, pf, o;
            pi = $urandom % 28 + 3;
            pf = ($urandom % 2) ? longint'($urandom % 65536) : 0;
            o  = (pi * 70) / 100;
            if (o < 1) o = 1;
            run_frame((pi << FRAC_W) | pf, o, $urandom % 30 + 10, 1'($urandom), 1'($urandom % 4 == 0));
        end
        // R1 reset in the middle of a frame
        @(negedge clk); observe(); rx = 1'b0;
        repeat (15) begin @(negedge clk); observe(); rx = 1'($urandom); end
        rst = 1'b1;
        repeat (2) begin @(negedge clk); observe(); end
        rst = 1'b0; rx = 1'b1;
        repeat (5) begin @(negedge clk); observe(); end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired at edge %0d", tick);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule